// File: doc/BRIEF.md
# Parallel NOR Flash Command Controller

This block models the command and status logic of a byte-wide parallel NOR flash device. A host drives chip enable, write enable, output enable, an address and a data byte. All of these are sampled on a system clock. The block watches each bus write cycle and decodes the multi-cycle unlock sequences. On a valid sequence it captures the target address and data and starts a timed embedded operation against a small internal byte array. The operation is a one-byte program, a sector erase or a whole-array erase.

While an operation is running, reads do not return array contents. They return a status byte instead. Bit 7 carries the complement of the final value being written (data polling). Bit 6 flips on every new read cycle (toggle). A host detects the end of the operation by either one. When the operation finishes, the block falls back to plain read mode without any command from the host. A low-supply input fences off every write cycle, so no command can begin and no cell can change while it is asserted.

Top module: `nor_flash_ctrl`

## Requirements
- R1: After reset every byte of the array reads 0xFF, and the command decoder is in read mode.
- R2: `dout_en` is 1 only while `ce_n`=0, `oe_n`=0 and `we_n`=1. Whenever `dout_en` is 0, `dout` is 0x00.
- R3: A write cycle is the clock where `ce_n`=0, `we_n`=0 and `we_n` was 1 one clock earlier. A program command is four write cycles in this order:
  - 0xAA at address 0x5555.
  - 0x55 at address 0x2AAA.
  - 0xA0 at 0x5555.
  - The data byte at the target address.

  Command addresses are compared on the low ADDR_W bits only: 0x155 and 0x2AA when ADDR_W=10. After the operation the target byte holds its old value AND the data byte.
- R4: The erase setup is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA. If the setup is followed by 0x30 at any address, every byte of that address's sector becomes 0xFF and every other byte is unchanged. A sector is the set of addresses that share bits ADDR_W-1 down to SECT_AW.
- R5: If the erase setup is followed by 0x10 at 0x5555, every byte of the array becomes 0xFF.
- R6: While an operation is busy, a read returns the following, and array data is returned again once the operation ends:
  - Bit 7 is the complement of bit 7 of the programmed data byte, or 0 during an erase.
  - Bits 5..0 are 0.
- R7: A read cycle starts on a clock where `ce_n`=0, `oe_n`=0 and `we_n`=1, and `oe_n` was 1 one clock earlier. During busy, bit 6 changes at every new read cycle. When idle it does not change, so two reads of one address are identical.
- R8: Busy lasts PROG_CYC clocks for a program. For an erase of an N-byte region it lasts 2*N + ERASE_CYC clocks: a preprogram pass of N clocks that writes every byte to 0x00, an ERASE_CYC wait, and an N-clock pass that writes 0xFF.
- R9: While `low_vcc`=1, no write cycle has any effect: no command starts and the array does not change.
- R10: A write of 0xF0 during any sequence step except the program data step returns the decoder to read mode. So does any write that does not match the expected step. In both cases the array is unchanged, and a later full sequence still works.
- R11: Write cycles issued while an operation is busy are ignored, including full command sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| low_vcc | input | 1 | Low-supply indication; blocks all write cycles while 1 |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data / command byte |
| dout | output | 8 | Read data or status byte |
| dout_en | output | 1 | High when the block drives the data bus |

## Verification
The program path is tried on a full sector in two passes:
- The first pass writes an address-derived pattern over erased bytes, which checks the address decode.
- The second pass writes an XOR pattern on top of it. Only a true AND merge gives the expected bytes, so it separates an AND merge from an overwrite.

Sector erase is aimed at a sector that holds scattered programmed bytes, while its neighbours hold other data. A full-array read-back then separates a confined erase from one that spills over. The busy window of each operation is timed against its formula. Broken unlock sequences, abort bytes, commands issued while busy and commands issued under low supply are each followed by reads, which show that no operation started and no byte moved.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

    // Command bus constants (addresses truncated to the array width by users)
    localparam logic [15:0] K_UNLK_A1 = 16'h5555;
    localparam logic [15:0] K_UNLK_A2 = 16'h2AAA;
    localparam logic [7:0]  K_KEY1    = 8'hAA;
    localparam logic [7:0]  K_KEY2    = 8'h55;
    localparam logic [7:0]  K_PROG    = 8'hA0;
    localparam logic [7:0]  K_ERASE   = 8'h80;
    localparam logic [7:0]  K_CHIP    = 8'h10;
    localparam logic [7:0]  K_SECT    = 8'h30;
    localparam logic [7:0]  K_ABORT   = 8'hF0;
    localparam logic [7:0]  K_ERASED  = 8'hFF;

    typedef enum logic [2:0] {
        C_READ, C_U1, C_U2, C_PARM, C_E1, C_E2, C_E3
    } cmd_state_t;

    typedef enum logic [1:0] {
        OP_PROG, OP_SECT, OP_CHIP
    } op_kind_t;

    typedef enum logic [2:0] {
        E_IDLE, E_PROG, E_PRE, E_WAIT, E_FILL
    } eng_state_t;

    typedef struct packed {
        op_kind_t   kind;
        logic [7:0] data;
    } op_cmd_t;

    // Programming can only clear bits
    function automatic logic [7:0] prog_merge(input logic [7:0] cur, input logic [7:0] req);
        return cur & req;
    endfunction

    // Byte presented on reads while an operation is in flight
    function automatic logic [7:0] status_byte(input logic poll7, input logic tog);
        return {poll7, tog, 6'b0};
    endfunction

endpackage

// File: rtl/flash_bus_port.sv
`timescale 1ns/1ps
module flash_bus_port (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic low_vcc,
    input  logic busy,
    output logic wr_stb,
    output logic tog
);
    logic we_q;
    logic oe_q;
    logic rd_stb;

    // Write cycle starts on the falling edge of we_n; supply monitor gates it
    assign wr_stb = !ce_n && !we_n && we_q && !low_vcc;
    assign rd_stb = !ce_n && !oe_n && we_n && oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q <= 1'b1;
            oe_q <= 1'b1;
            tog  <= 1'b0;
        end else begin
            we_q <= we_n;
            oe_q <= oe_n;
            if (rd_stb && busy)
                tog <= ~tog;
        end
    end

    // R7: the toggle bit is frozen whenever no operation is in flight
    p_tog_frozen_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(tog));

endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              busy,
    output logic              start,
    output op_cmd_t           cmd,
    output logic [ADDR_W-1:0] cmd_addr
);
    localparam logic [ADDR_W-1:0] A1 = K_UNLK_A1[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A2 = K_UNLK_A2[ADDR_W-1:0];

    cmd_state_t state;
    logic       hit1;
    logic       hit2;

    assign hit1 = (addr == A1);
    assign hit2 = (addr == A2);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= C_READ;
            start    <= 1'b0;
            cmd      <= '{kind: OP_PROG, data: 8'h00};
            cmd_addr <= '0;
        end else begin
            start <= 1'b0;
            if (wr_stb && !busy) begin
                if (din == K_ABORT && state != C_PARM) begin
                    state <= C_READ;
                end else begin
                    case (state)
                        C_READ: state <= (hit1 && din == K_KEY1) ? C_U1 : C_READ;
                        C_U1:   state <= (hit2 && din == K_KEY2) ? C_U2 : C_READ;
                        C_U2: begin
                            if (hit1 && din == K_PROG)
                                state <= C_PARM;
                            else if (hit1 && din == K_ERASE)
                                state <= C_E1;
                            else
                                state <= C_READ;
                        end
                        C_PARM: begin
                            start    <= 1'b1;
                            cmd      <= '{kind: OP_PROG, data: din};
                            cmd_addr <= addr;
                            state    <= C_READ;
                        end
                        C_E1:   state <= (hit1 && din == K_KEY1) ? C_E2 : C_READ;
                        C_E2:   state <= (hit2 && din == K_KEY2) ? C_E3 : C_READ;
                        C_E3: begin
                            if (hit1 && din == K_CHIP) begin
                                start    <= 1'b1;
                                cmd      <= '{kind: OP_CHIP, data: K_ERASED};
                                cmd_addr <= addr;
                            end else if (din == K_SECT) begin
                                start    <= 1'b1;
                                cmd      <= '{kind: OP_SECT, data: K_ERASED};
                                cmd_addr <= addr;
                            end
                            state <= C_READ;
                        end
                        default: state <= C_READ;
                    endcase
                end
            end
        end
    end

    // R11: the decoder does not move while an operation is in flight
    p_hold_when_busy_r11: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(state));

    // R3: an operation is only launched into an idle engine
    p_start_only_idle_r3: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

endmodule

// File: rtl/flash_op_engine.sv
`timescale 1ns/1ps
module flash_op_engine
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int SECT_AW   = 8,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  op_cmd_t           cmd,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        old_byte,
    output logic              busy,
    output logic              poll7,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic [ADDR_W-1:0] eng_raddr
);
    localparam int SECT_BYTES = 1 << SECT_AW;
    localparam logic [31:0] PROG_LAST  = 32'(PROG_CYC - 1);
    localparam logic [31:0] ERASE_LAST = 32'(ERASE_CYC - 1);

    eng_state_t        st;
    op_kind_t          kind;
    logic [31:0]       cnt;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] last;
    logic [ADDR_W-1:0] tgt_addr;
    logic [7:0]        tgt_data;
    logic              walk_end;

    assign busy      = (st != E_IDLE);
    assign poll7     = (kind == OP_PROG) ? ~tgt_data[7] : 1'b0;
    assign eng_raddr = tgt_addr;
    assign walk_end  = (cnt[ADDR_W-1:0] == last);

    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = base + cnt[ADDR_W-1:0];
        mem_wdata = 8'h00;
        case (st)
            E_PROG: begin
                mem_we    = (cnt == PROG_LAST);
                mem_waddr = tgt_addr;
                mem_wdata = prog_merge(old_byte, tgt_data);
            end
            E_PRE: begin
                mem_we    = 1'b1;
                mem_wdata = 8'h00;
            end
            E_FILL: begin
                mem_we    = 1'b1;
                mem_wdata = K_ERASED;
            end
            default: mem_we = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= E_IDLE;
            kind     <= OP_PROG;
            cnt      <= '0;
            base     <= '0;
            last     <= '0;
            tgt_addr <= '0;
            tgt_data <= K_ERASED;
        end else begin
            case (st)
                E_IDLE: begin
                    if (start) begin
                        cnt      <= '0;
                        kind     <= cmd.kind;
                        tgt_addr <= cmd_addr;
                        tgt_data <= cmd.data;
                        case (cmd.kind)
                            OP_SECT: begin
                                base <= {cmd_addr[ADDR_W-1:SECT_AW], {SECT_AW{1'b0}}};
                                last <= ADDR_W'(SECT_BYTES - 1);
                                st   <= E_PRE;
                            end
                            OP_CHIP: begin
                                base <= '0;
                                last <= '1;
                                st   <= E_PRE;
                            end
                            default: st <= E_PROG;
                        endcase
                    end
                end
                E_PROG: begin
                    if (cnt == PROG_LAST) st <= E_IDLE;
                    else cnt <= cnt + 32'd1;
                end
                E_PRE: begin
                    if (walk_end) begin
                        cnt <= '0;
                        st  <= E_WAIT;
                    end else cnt <= cnt + 32'd1;
                end
                E_WAIT: begin
                    if (cnt == ERASE_LAST) begin
                        cnt <= '0;
                        st  <= E_FILL;
                    end else cnt <= cnt + 32'd1;
                end
                E_FILL: begin
                    if (walk_end) st <= E_IDLE;
                    else cnt <= cnt + 32'd1;
                end
                default: st <= E_IDLE;
            endcase
        end
    end

    // R4: sector erase writes never leave the addressed sector
    p_sector_confine_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_we && kind == OP_SECT && st != E_PROG)
            |-> (mem_waddr[ADDR_W-1:SECT_AW] == tgt_addr[ADDR_W-1:SECT_AW]));

    // R8: an operation ends only after its final write
    p_end_after_write_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(mem_we));

endmodule

// File: rtl/flash_store.sv
`timescale 1ns/1ps
module flash_store #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [7:0]        rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [7:0]        rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= 8'hFF;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/nor_flash_ctrl.sv
`timescale 1ns/1ps
module nor_flash_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int SECT_AW   = 8,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              low_vcc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en
);
    logic              wr_stb;
    logic              tog;
    logic              busy;
    logic              poll7;
    logic              start;
    op_cmd_t           cmd;
    logic [ADDR_W-1:0] cmd_addr;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata;
    logic [ADDR_W-1:0] eng_raddr;
    logic [7:0]        rd_byte;
    logic [7:0]        old_byte;

    flash_bus_port u_port (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .low_vcc(low_vcc), .busy(busy), .wr_stb(wr_stb), .tog(tog)
    );

    flash_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .addr(addr), .din(din),
        .busy(busy), .start(start), .cmd(cmd), .cmd_addr(cmd_addr)
    );

    flash_op_engine #(
        .ADDR_W(ADDR_W), .SECT_AW(SECT_AW),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_eng (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .cmd_addr(cmd_addr),
        .old_byte(old_byte), .busy(busy), .poll7(poll7), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .eng_raddr(eng_raddr)
    );

    flash_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr_a(addr), .rdata_a(rd_byte), .raddr_b(eng_raddr), .rdata_b(old_byte)
    );

    assign dout_en = !ce_n && !oe_n && we_n;

    always_comb begin
        if (!dout_en)
            dout = 8'h00;
        else if (busy)
            dout = status_byte(poll7, tog);
        else
            dout = rd_byte;
    end

    // R9: with low supply flagged, no operation can be launched
    p_lowvcc_no_start_r9: assert property (@(posedge clk) disable iff (rst)
        (low_vcc && !busy) |=> !start);

    // R6: status bits 5..0 read as zero while busy
    p_status_low_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && dout_en) |-> (dout[5:0] == 6'b0));

endmodule

// File: tb/nor_flash_ctrl_bench.sv
`timescale 1ns/1ps
module nor_flash_ctrl_bench;
    localparam int AW     = 10;
    localparam int SAW    = 8;
    localparam int PC     = 8;
    localparam int EC     = 16;
    localparam int DEPTH  = 1 << AW;
    localparam int SBYTES = 1 << SAW;
    localparam logic [AW-1:0] A1 = 10'h155;
    localparam logic [AW-1:0] A2 = 10'h2AA;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, low_vcc = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] model [DEPTH];

    nor_flash_ctrl #(.ADDR_W(AW), .SECT_AW(SAW), .PROG_CYC(PC), .ERASE_CYC(EC)) u_nor_flash_ctrl (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .low_vcc(low_vcc), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; addr = a; din = d; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
        @(negedge clk); d = dout; oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic do_program(input logic [AW-1:0] a, input logic [7:0] d);
        bus_write(A1, 8'hAA); bus_write(A2, 8'h55); bus_write(A1, 8'hA0); bus_write(a, d);
    endtask

    task automatic erase_setup();
        bus_write(A1, 8'hAA); bus_write(A2, 8'h55); bus_write(A1, 8'h80);
        bus_write(A1, 8'hAA); bus_write(A2, 8'h55);
    endtask

    // Reads pairs until the toggle bit stops moving
    task automatic wait_done(input string tag);
        logic [7:0] r1, r2;
        bit done = 1'b0;
        for (int i = 0; i < 3000 && !done; i++) begin
            bus_read('0, r1);
            bus_read('0, r2);
            if (r1 == r2) done = 1'b1;
        end
        check(done, tag, 0, 1);
    endtask

    // Holds a read open and counts clocks with DQ7 low
    task automatic measure_busy(input logic [AW-1:0] a, output int n);
        n = 0;
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (dout[7] == 1'b0) n++;
            else break;
        end
        oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic verify_all(input string tag);
        logic [7:0] r;
        for (int a = 0; a < DEPTH; a++) begin
            bus_read(AW'(a), r);
            check(r == model[a], tag, int'(r), int'(model[a]));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] r, r2;
        int n;
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R2: output enable rule
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
        #1 check(dout_en == 1'b0 && dout == 8'h00, "R2 ce_n high", int'(dout_en), 0);
        ce_n = 1'b0; oe_n = 1'b1;
        #1 check(dout_en == 1'b0 && dout == 8'h00, "R2 oe_n high", int'(dout_en), 0);
        din = 8'hF0; we_n = 1'b0; oe_n = 1'b0;
        #1 check(dout_en == 1'b0 && dout == 8'h00, "R2 we_n low", int'(dout_en), 0);
        @(negedge clk); we_n = 1'b1;
        #1 check(dout_en == 1'b1 && dout == 8'hFF, "R2 driving", int'(dout), 8'hFF);
        @(negedge clk); oe_n = 1'b1; ce_n = 1'b1;

        // R1: erased after reset
        verify_all("R1 reset contents");

        // R6 / R7: status during a program, data afterwards
        do_program(10'h3A5, 8'h3C);
        bus_read('0, r);
        bus_read('0, r2);
        check(r[7] == 1'b1, "R6 poll bit", int'(r[7]), 1);
        check(r[5:0] == 6'b0, "R6 low bits", int'(r[5:0]), 0);
        check(r[6] != r2[6], "R7 toggles while busy", int'(r2[6]), int'(~r[6]));
        wait_done("R7 toggle stops");
        model[10'h3A5] = 8'h3C;
        bus_read(10'h3A5, r);
        check(r == 8'h3C, "R6 back to read mode", int'(r), 8'h3C);
        bus_read(10'h3A5, r2);
        check(r == r2, "R7 idle reads stable", int'(r2), int'(r));

        // R8: program busy window
        do_program(10'h3F0, 8'h80);
        measure_busy(10'h3F0, n);
        model[10'h3F0] = 8'h80;
        check(n >= PC - 3 && n <= PC + 1, "R8 program duration", n, PC - 2);

        // R3: two-pass program sweep over sector 1
        for (int i = 0; i < SBYTES; i++) begin
            do_program(AW'(SBYTES + i), 8'((i * 37 + 5) & 8'hFF));
            wait_done("R3 pass1");
            model[SBYTES + i] = 8'((i * 37 + 5) & 8'hFF);
        end
        for (int i = 0; i < SBYTES; i++) begin
            do_program(AW'(SBYTES + i), 8'(i) ^ 8'h5A);
            wait_done("R3 pass2");
            model[SBYTES + i] = model[SBYTES + i] & (8'(i) ^ 8'h5A);
        end
        verify_all("R3 program AND merge");

        // R4: sector erase confined to sector 2
        for (int i = 0; i < 16; i++) begin
            do_program(AW'(2 * SBYTES + i * 16), 8'(i));
            wait_done("R4 setup");
            model[2 * SBYTES + i * 16] = 8'(i);
        end
        erase_setup(); bus_write(10'h2A7, 8'h30);
        wait_done("R4 erase end");
        for (int i = 0; i < SBYTES; i++) model[2 * SBYTES + i] = 8'hFF;
        verify_all("R4 sector erase");

        // R8: erase busy window on sector 0
        erase_setup(); bus_write(10'h0C3, 8'h30);
        measure_busy('0, n);
        check(n >= 2 * SBYTES + EC - 3 && n <= 2 * SBYTES + EC + 1,
              "R8 sector erase duration", n, 2 * SBYTES + EC - 2);

        // R10: aborts and broken sequences
        bus_write(A1, 8'hAA); bus_write(A2, 8'h55); bus_write(10'h007, 8'hF0); bus_write(10'h111, 8'h00);
        bus_read(10'h111, r); bus_read(10'h111, r2);
        check(r == model[10'h111] && r == r2, "R10 abort byte", int'(r), int'(model[10'h111]));
        bus_write(A1, 8'hAA); bus_write(10'h123, 8'h55); bus_write(A1, 8'hA0); bus_write(10'h111, 8'h00);
        bus_read(10'h111, r);
        check(r == model[10'h111], "R10 broken unlock", int'(r), int'(model[10'h111]));
        erase_setup(); bus_write(10'h033, 8'hF0); bus_write(A1, 8'h10);
        bus_read(10'h111, r); bus_read(10'h111, r2);
        check(r == model[10'h111] && r == r2, "R10 erase aborted", int'(r), int'(model[10'h111]));
        do_program(10'h111, 8'h0F);
        wait_done("R10 recover");
        model[10'h111] = model[10'h111] & 8'h0F;
        bus_read(10'h111, r);
        check(r == model[10'h111], "R10 sequence after abort", int'(r), int'(model[10'h111]));

        // R11: commands during busy are ignored
        erase_setup(); bus_write(10'h3C0, 8'h30);
        do_program(10'h050, 8'h00);
        bus_write(10'h000, 8'hF0);
        wait_done("R11 erase end");
        for (int i = 0; i < SBYTES; i++) model[3 * SBYTES + i] = 8'hFF;
        bus_read(10'h050, r);
        check(r == 8'hFF, "R11 program while busy ignored", int'(r), 8'hFF);
        bus_read(10'h3A5, r);
        check(r == 8'hFF, "R11 erase still completed", int'(r), 8'hFF);

        // R9: low supply blocks all writes
        low_vcc = 1'b1;
        do_program(10'h051, 8'h00);
        erase_setup(); bus_write(A1, 8'h10);
        low_vcc = 1'b0;
        bus_read(10'h051, r); bus_read(10'h051, r2);
        check(r == 8'hFF && r == r2, "R9 low supply program", int'(r), 8'hFF);
        bus_read(10'h111, r);
        check(r == model[10'h111], "R9 low supply erase", int'(r), int'(model[10'h111]));
        do_program(10'h051, 8'h55);
        wait_done("R9 recover");
        model[10'h051] = 8'h55;
        bus_read(10'h051, r);
        check(r == 8'h55, "R9 writes resume", int'(r), 8'h55);

        // R5 / R8: chip erase
        erase_setup(); bus_write(A1, 8'h10);
        measure_busy('0, n);
        check(n >= 2 * DEPTH + EC - 3 && n <= 2 * DEPTH + EC + 1,
              "R8 chip erase duration", n, 2 * DEPTH + EC - 2);
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
        verify_all("R5 chip erase");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule